// File: doc/BRIEF.md
# Decimated Shared-File Sync Correlator

This block locates the FFT-window boundary of an OFDM burst. It correlates incoming complex samples with a known 128-point sync sequence and searches one symbol's worth of candidate offsets for the strongest match. A full matched filter would need 128 complex taps and would reload its whole sample store on every sample. This block uses only 32 taps instead. It keeps one 32-word register file, filled with every fourth accepted sample. Four consecutive candidate offsets read the same stored words, and each of the four offsets uses a different quarter (phase group) of the coefficients. The result is one correlation metric per accepted sample at full timing resolution, while the register file takes one new word every four samples.

The coefficients are held as sign bits (+1 or −1), so each tap adds or subtracts a sample's I and Q parts. The metric is the L1 magnitude |Re|+|Im|. An upstream packet detector pulses `start` to open a search window. After the last offset of the window, the block emits a one-cycle boundary pulse that carries the offset with the largest metric. The approximation is sound only because the sync sequence has equal power at every sample, so any phase group is as good as any other.

Top module: `ffw_matched_sync`

## Requirements
- R1: After reset, `corr_vld` and `bnd_vld` are low, and no metric or boundary is produced until `start` has been seen.
- R2: A `start` pulse opens a window. Accepted samples (cycles with `in_vld` high and `start` low) are numbered t = 0, 1, 2, … . The metric for offset k (k = 0…WIN−1, WIN = 165) appears on `corr_mag`, with `corr_idx` = k and `corr_vld` high, one clock after sample t = TAPS + k is accepted. Exactly WIN metrics are produced per window.
- R3: With RED = 4 and SUB = 32, let g = RED−1−(k mod RED), and let c(i) = −1 when bit i of `COEF` is 1, else +1. Then Re(k) = Σ_{n=0}^{SUB−1} c(RED·n+g)·I[k+g+RED·n], and Im(k) is the same sum over Q.
- R4: `corr_mag` = |Re(k)|+|Im(k)| is exact for full-scale two's-complement inputs. It never exceeds 2·SUB·2^(W−1).
- R5: Cycles with `in_vld` low are skipped. They do not advance the sample count and do not alter any metric or the boundary.
- R6: One cycle after the metric of offset WIN−1, `bnd_vld` pulses for exactly one cycle. `bnd_idx` is the smallest offset whose metric equals the window maximum.
- R7: After a window completes, further accepted samples produce no metric and no boundary until the next `start`.
- R8: A `start` during an open window abandons that window. Numbering restarts at t = 0, and the outputs describe only the new window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Opens (or reopens) a search window |
| in_vld | input | 1 | Sample strobe |
| in_i | input | W | Signed in-phase sample |
| in_q | input | W | Signed quadrature sample |
| corr_vld | output | 1 | Metric valid |
| corr_idx | output | IDX_W | Candidate offset of the metric |
| corr_mag | output | MAG_W | Metric \|Re\|+\|Im\| |
| bnd_vld | output | 1 | Boundary result pulse |
| bnd_idx | output | IDX_W | Offset of the earliest maximum |

## Verification
Random full-range samples check the correlation arithmetic and the phase-group rotation at every offset. Any mix-up of group order or sample alignment shows up as a mismatch within four offsets. A sync sequence embedded at a chosen offset checks that the peak lands on that alignment, including the very last offset of the window. An all-zero input and a full-scale pattern separate correct tie-breaking from a later-wins compare, and correct magnitude width from overflow. Random gaps in the strobe, a restart partway into a window, and samples fed after a window ends show whether stalls, abandoned windows and stray input leak into the results.

// File: rtl/ffw_pkg.sv
package ffw_pkg;
   // Width needed to index n items; never less than one bit.
   function automatic int unsigned bits_for(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

   typedef enum logic [0:0] {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } ffw_state_e;
endpackage

// File: rtl/ffw_dline.sv
// Decimated sample store: shifts in one complex word per load strobe.
module ffw_dline #(
   parameter int W     = 8,
   parameter int DEPTH = 32
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        ld,
   input  logic signed [W-1:0]         di,
   input  logic signed [W-1:0]         dq,
   output logic [DEPTH-1:0][W-1:0]     wi,
   output logic [DEPTH-1:0][W-1:0]     wq
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wi <= '0;
         wq <= '0;
      end else if (ld) begin
         for (int n = 0; n < DEPTH - 1; n++) begin
            wi[n] <= wi[n+1];
            wq[n] <= wq[n+1];
         end
         wi[DEPTH-1] <= di;
         wq[DEPTH-1] <= dq;
      end
   end
endmodule

// File: rtl/ffw_corr.sv
// Sign-coefficient correlator over the shared store; grp picks the phase group.
module ffw_corr #(
   parameter int               W     = 8,
   parameter int               DEPTH = 32,
   parameter int               RED   = 4,
   parameter int               TAPS  = 128,
   parameter logic [TAPS-1:0]  COEF  = '0,
   parameter int               GRP_W = 2,
   parameter int               ACC_W = 14,
   parameter int               MAG_W = 14
) (
   input  logic [DEPTH-1:0][W-1:0] wi,
   input  logic [DEPTH-1:0][W-1:0] wq,
   input  logic [GRP_W-1:0]        grp,
   output logic [MAG_W-1:0]        mag
);
   logic [DEPTH-1:0]         neg;
   logic signed [ACC_W-1:0]  acc_i, acc_q;
   logic [ACC_W-1:0]         abs_i, abs_q;

   for (genvar n = 0; n < DEPTH; n++) begin : g_tap
      if (RED == 1) begin : g_full
         assign neg[n] = COEF[n];
      end else begin : g_rot
         localparam logic [RED-1:0] CG = COEF[RED*n +: RED];
         assign neg[n] = CG[grp];
      end
   end

   always_comb begin
      logic signed [ACC_W-1:0] ei, eq;
      acc_i = '0;
      acc_q = '0;
      for (int n = 0; n < DEPTH; n++) begin
         ei = {{(ACC_W-W){wi[n][W-1]}}, wi[n]};
         eq = {{(ACC_W-W){wq[n][W-1]}}, wq[n]};
         acc_i = neg[n] ? acc_i - ei : acc_i + ei;
         acc_q = neg[n] ? acc_q - eq : acc_q + eq;
      end
      abs_i = acc_i[ACC_W-1] ? ACC_W'(-acc_i) : ACC_W'(acc_i);
      abs_q = acc_q[ACC_W-1] ? ACC_W'(-acc_q) : ACC_W'(acc_q);
      mag   = MAG_W'(abs_i) + MAG_W'(abs_q);
   end
endmodule

// File: rtl/ffw_peak.sv
// Running maximum over one window; strict compare keeps the earliest peak.
module ffw_peak #(
   parameter int WIN   = 165,
   parameter int IDX_W = 8,
   parameter int MAG_W = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             vld,
   input  logic [IDX_W-1:0] idx,
   input  logic [MAG_W-1:0] mag,
   output logic             bvld,
   output logic [IDX_W-1:0] bidx
);
   logic [MAG_W-1:0] best;
   logic [IDX_W-1:0] best_idx;
   logic             take;

   assign take = (idx == '0) || (mag > best);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         best     <= '0;
         best_idx <= '0;
         bvld     <= 1'b0;
         bidx     <= '0;
      end else begin
         bvld <= 1'b0;
         if (vld) begin
            if (take) begin
               best     <= mag;
               best_idx <= idx;
            end
            if (idx == IDX_W'(WIN - 1)) begin
               bvld <= 1'b1;
               bidx <= take ? idx : best_idx;
            end
         end
      end
   end
endmodule

// File: rtl/ffw_matched_sync.sv
module ffw_matched_sync
   import ffw_pkg::*;
#(
   parameter int              W    = 8,
   parameter int              TAPS = 128,
   parameter int              RED  = 4,
   parameter int              WIN  = 165,
   parameter logic [TAPS-1:0] COEF = 128'hC3A5_96F0_1E2D_B478_5A69_0FF1_E3C7_8B4D,
   localparam int SUB   = TAPS / RED,
   localparam int GRP_W = bits_for(RED),
   localparam int ACC_W = W + $clog2(SUB) + 1,
   localparam int MAG_W = ACC_W,
   localparam int IDX_W = bits_for(WIN)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic                in_vld,
   input  logic signed [W-1:0] in_i,
   input  logic signed [W-1:0] in_q,
   output logic                corr_vld,
   output logic [IDX_W-1:0]    corr_idx,
   output logic [MAG_W-1:0]    corr_mag,
   output logic                bnd_vld,
   output logic [IDX_W-1:0]    bnd_idx
);
   localparam int CNT_W = $clog2(TAPS + WIN + 1);
   localparam int LAST  = TAPS + WIN - 1;

   if (W < 2) begin : g_bad_w
      $error("sample width must be at least 2");
   end
   if (RED < 1 || (RED & (RED - 1)) != 0) begin : g_bad_red
      $error("reduction factor must be a power of two");
   end
   if (TAPS % RED != 0 || SUB < 2) begin : g_bad_taps
      $error("tap count must be a multiple of the reduction factor");
   end
   if (WIN < 1) begin : g_bad_win
      $error("window must hold at least one offset");
   end

   ffw_state_e               st;
   logic [CNT_W-1:0]         cnt;
   logic                     take, cen, ld;
   logic [GRP_W-1:0]         grp;
   logic [SUB-1:0][W-1:0]    wi, wq;
   logic [MAG_W-1:0]         mag;

   assign take = (st == ST_RUN) && in_vld && !start;
   assign cen  = take && (cnt >= CNT_W'(TAPS));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= ST_IDLE;
         cnt <= '0;
      end else if (start) begin
         st  <= ST_RUN;
         cnt <= '0;
      end else if (take) begin
         cnt <= cnt + 1'b1;
         if (cnt == CNT_W'(LAST)) st <= ST_IDLE;
      end
   end

   if (RED == 1) begin : g_norot
      assign grp = '0;
      assign ld  = take;
   end else begin : g_rot
      logic [GRP_W-1:0] ph;
      assign ph  = cnt[GRP_W-1:0];
      assign grp = ~ph;
      assign ld  = take && (&ph);
   end

   ffw_dline #(.W(W), .DEPTH(SUB)) u_dline (
      .clk(clk), .rst_n(rst_n), .ld(ld),
      .di(in_i), .dq(in_q), .wi(wi), .wq(wq)
   );

   ffw_corr #(
      .W(W), .DEPTH(SUB), .RED(RED), .TAPS(TAPS), .COEF(COEF),
      .GRP_W(GRP_W), .ACC_W(ACC_W), .MAG_W(MAG_W)
   ) u_corr (
      .wi(wi), .wq(wq), .grp(grp), .mag(mag)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         corr_vld <= 1'b0;
         corr_idx <= '0;
         corr_mag <= '0;
      end else begin
         corr_vld <= cen;
         if (cen) begin
            corr_idx <= IDX_W'(cnt - CNT_W'(TAPS));
            corr_mag <= mag;
         end
      end
   end

   ffw_peak #(.WIN(WIN), .IDX_W(IDX_W), .MAG_W(MAG_W)) u_peak (
      .clk(clk), .rst_n(rst_n), .vld(corr_vld), .idx(corr_idx),
      .mag(corr_mag), .bvld(bnd_vld), .bidx(bnd_idx)
   );
endmodule

// File: rtl/ffw_sync_chk.sv
module ffw_sync_chk #(
   parameter int W     = 8,
   parameter int TAPS  = 128,
   parameter int RED   = 4,
   parameter int WIN   = 165,
   parameter int IDX_W = 8,
   parameter int MAG_W = 14
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             in_vld,
   input logic             corr_vld,
   input logic [IDX_W-1:0] corr_idx,
   input logic [MAG_W-1:0] corr_mag,
   input logic             bnd_vld,
   input logic [IDX_W-1:0] bnd_idx
);
   localparam int SUB     = TAPS / RED;
   localparam int MAG_MAX = 2 * SUB * (2 ** (W - 1));

   // R5
   metric_needs_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
      corr_vld |-> ($past(in_vld) && !$past(start)));

   // R2
   offset_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      corr_vld |-> (corr_idx < IDX_W'(WIN)));

   // R2
   offsets_consecutive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (corr_vld && $past(corr_vld)) |-> (corr_idx == $past(corr_idx) + 1'b1));

   // R4
   mag_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      corr_vld |-> (corr_mag <= MAG_W'(MAG_MAX)));

   // R6
   bnd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bnd_vld |=> !bnd_vld);

   // R6
   bnd_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bnd_vld |-> ($past(corr_vld) && $past(corr_idx) == IDX_W'(WIN - 1)
                   && bnd_idx < IDX_W'(WIN)));
endmodule

bind ffw_matched_sync ffw_sync_chk #(
   .W(W), .TAPS(TAPS), .RED(RED), .WIN(WIN), .IDX_W(IDX_W), .MAG_W(MAG_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .in_vld(in_vld),
   .corr_vld(corr_vld), .corr_idx(corr_idx), .corr_mag(corr_mag),
   .bnd_vld(bnd_vld), .bnd_idx(bnd_idx)
);

// File: tb/sim_ffw_matched_sync.sv
module sim_ffw_matched_sync;
   localparam int W    = 8;
   localparam int TAPS = 128;
   localparam int RED  = 4;
   localparam int WIN  = 165;
   localparam logic [TAPS-1:0] COEF = 128'hC3A5_96F0_1E2D_B478_5A69_0FF1_E3C7_8B4D;
   localparam int SUB   = TAPS / RED;
   localparam int NS    = TAPS + WIN;
   localparam int IDX_W = $clog2(WIN);
   localparam int MAG_W = W + $clog2(SUB) + 1;

   logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, in_vld = 1'b0;
   logic signed [W-1:0] in_i = '0, in_q = '0;
   logic             corr_vld, bnd_vld;
   logic [IDX_W-1:0] corr_idx, bnd_idx;
   logic [MAG_W-1:0] corr_mag;

   always #2 clk = ~clk;

   ffw_matched_sync #(.W(W), .TAPS(TAPS), .RED(RED), .WIN(WIN), .COEF(COEF)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .in_vld(in_vld),
      .in_i(in_i), .in_q(in_q), .corr_vld(corr_vld), .corr_idx(corr_idx),
      .corr_mag(corr_mag), .bnd_vld(bnd_vld), .bnd_idx(bnd_idx)
   );

   int nchk = 0, nerr = 0;
   int si[NS], sq[NS];
   int exp_mag[WIN];
   int exp_b;
   int got_corr, got_bnd, next_idx;
   bit mon_on = 1'b0;
   string mag_req = "R3";

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int expv);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
      end
   endtask

   function automatic int cval(input int i);
      return COEF[i] ? -1 : 1;
   endfunction

   // R3 / R4 reference metric
   function automatic int model(input int k);
      int g, re, im;
      g = RED - 1 - (k % RED);
      re = 0; im = 0;
      for (int n = 0; n < SUB; n++) begin
         re += cval(RED*n + g) * si[k + g + RED*n];
         im += cval(RED*n + g) * sq[k + g + RED*n];
      end
      return (re < 0 ? -re : re) + (im < 0 ? -im : im);
   endfunction

   task automatic build_exp();
      int best;
      best = -1;
      for (int k = 0; k < WIN; k++) begin
         exp_mag[k] = model(k);
         if (exp_mag[k] > best) begin best = exp_mag[k]; exp_b = k; end
      end
   endtask

   function automatic int rnd_s();
      return int'($urandom % 256) - 128;
   endfunction

   always @(negedge clk) begin
      if (mon_on) begin
         if (corr_vld) begin
            chk(int'(corr_idx) == next_idx, "R2", "corr_idx", int'(corr_idx), next_idx);
            if (int'(corr_idx) < WIN)
               chk(int'(corr_mag) == exp_mag[corr_idx], mag_req, "corr_mag",
                   int'(corr_mag), exp_mag[corr_idx]);
            next_idx++;
            got_corr++;
         end
         if (bnd_vld) begin
            got_bnd++;
            chk(int'(bnd_idx) == exp_b, "R6", "bnd_idx", int'(bnd_idx), exp_b);
         end
      end
   end

   task automatic drive(input int t, input bit gaps);
      if (gaps) begin
         while ($urandom % 3 == 0) begin
            in_vld = 1'b0;
            @(negedge clk);
         end
      end
      in_vld = 1'b1;
      in_i = si[t][W-1:0];
      in_q = sq[t][W-1:0];
      @(negedge clk);
   endtask

   task automatic run(input bit gaps);
      build_exp();
      start = 1'b1; in_vld = 1'b0;
      @(negedge clk);
      start = 1'b0;
      next_idx = 0; got_corr = 0; got_bnd = 0; mon_on = 1'b1;
      for (int t = 0; t < NS; t++) drive(t, gaps);
      in_vld = 1'b0;
      repeat (4) @(negedge clk);
      chk(got_corr == WIN, "R2", "metric count", got_corr, WIN);
      chk(got_bnd == 1, "R6", "boundary pulses", got_bnd, 1);
      // R7: samples after the window are ignored
      for (int e = 0; e < 12; e++) begin
         in_vld = 1'b1; in_i = W'(rnd_s()); in_q = W'(rnd_s());
         @(negedge clk);
      end
      in_vld = 1'b0;
      repeat (3) @(negedge clk);
      chk(got_corr == WIN, "R7", "metrics after window", got_corr, WIN);
      chk(got_bnd == 1, "R7", "boundaries after window", got_bnd, 1);
      mon_on = 1'b0;
   endtask

   task automatic fill_rand();
      for (int t = 0; t < NS; t++) begin si[t] = rnd_s(); sq[t] = rnd_s(); end
   endtask

   task automatic fill_sync(input int pos, input int amp);
      for (int t = 0; t < NS; t++) begin si[t] = 0; sq[t] = 0; end
      for (int i = 0; i < TAPS; i++) begin
         si[pos + i] = cval(i) * amp;
         sq[pos + i] = cval(i) * (amp / 2);
      end
   endtask

   task automatic summary();
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nerr);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      nchk++; nerr++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      summary();
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_0042));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: idle after reset
      chk(corr_vld == 1'b0, "R1", "corr_vld after reset", int'(corr_vld), 0);
      chk(bnd_vld == 1'b0, "R1", "bnd_vld after reset", int'(bnd_vld), 0);
      got_corr = 0; got_bnd = 0; next_idx = 0; mon_on = 1'b1;
      for (int t = 0; t < NS; t++) begin
         in_vld = 1'b1; in_i = W'(rnd_s()); in_q = W'(rnd_s());
         @(negedge clk);
      end
      in_vld = 1'b0;
      repeat (3) @(negedge clk);
      mon_on = 1'b0;
      chk(got_corr == 0, "R1", "metrics without start", got_corr, 0);
      chk(got_bnd == 0, "R1", "boundaries without start", got_bnd, 0);

      // R3: random full-range samples, several seeds
      for (int r = 0; r < 3; r++) begin
         mag_req = "R3";
         fill_rand();
         run(1'b0);
      end

      // R6: embedded sync sequence at an interior offset
      mag_req = "R6";
      fill_sync(37, 90);
      run(1'b0);
      chk(exp_b == 37, "R6", "model peak position", exp_b, 37);

      // R6: all-zero input, every metric ties, earliest offset wins
      for (int t = 0; t < NS; t++) begin si[t] = 0; sq[t] = 0; end
      run(1'b0);
      chk(exp_b == 0, "R6", "tie peak position", exp_b, 0);

      // R4: full-scale aligned pattern drives the metric to its bound
      mag_req = "R4";
      for (int t = 0; t < NS; t++) begin si[t] = 0; sq[t] = 0; end
      for (int i = 0; i < TAPS; i++) begin
         si[i] = (cval(i) > 0) ? -128 : 127;
         sq[i] = (cval(i) > 0) ? -128 : 127;
      end
      run(1'b0);

      // R5: random samples with random strobe gaps
      mag_req = "R5";
      fill_rand();
      run(1'b1);

      // R8: abandon a window part way, restart with peak at the last offset
      mag_req = "R8";
      start = 1'b1; @(negedge clk); start = 1'b0;
      for (int t = 0; t < 150; t++) begin
         in_vld = 1'b1; in_i = W'(rnd_s()); in_q = W'(rnd_s());
         @(negedge clk);
      end
      in_vld = 1'b0;
      fill_sync(WIN - 1, 60);
      for (int t = 0; t < WIN - 1; t++) begin
         si[t] = int'($urandom % 9) - 4; sq[t] = int'($urandom % 9) - 4;
      end
      run(1'b1);
      chk(exp_b == WIN - 1, "R8", "restart peak position", exp_b, WIN - 1);

      summary();
      $finish;
   end
endmodule